// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two 32-bit words and an incoming carry. It is purely combinational. The word is cut into four 8-bit groups. Inside a group, the carry into each bit position is built as a flat sum of products. The terms are the per-bit generate (A_i AND B_i), the per-bit propagate (A_i OR B_i) and the carry entering that group. No carry inside a group waits on a neighbouring bit. The carry leaving one group becomes the carry entering the next higher group, and the lowest group takes the external carry. The group carries therefore pass along a short chain of four links rather than a 32-bit chain.

An enclosing arithmetic unit uses the block as its adder. The block brings out three results: the 32-bit sum, the carry out of the top bit, and the carry into the top bit. The unit can form signed overflow as the exclusive-OR of the last two carries. The group width is a parameter and must divide the word width.

Top module: `cla_grouped_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^32, with all operands taken as unsigned.
- R2: `cout_o` equals bit 32 of the 33-bit unsigned total `a_i` + `b_i` + `cin_i`.
- R3: `c_msb_o` equals the carry entering bit 31. This is bit 31 of (`a_i`[30:0] + `b_i`[30:0] + `cin_i`). It also always equals `a_i`[31] XOR `b_i`[31] XOR `sum_o`[31].
- R4: A carry entering the lowest bit travels through a word whose every position only propagates, so 0xFFFFFFFF + 0 + 1 gives sum 0 and carry-out 1.
- R5: The carry leaving the low group at each 8-bit boundary (after bits 7, 15 and 23) enters the next group. For example, 0x000000FF + 0 + 1 gives 0x00000100, and 0x00FFFFFF + 1 gives 0x01000000.
- R6: A carry generated at any single bit position i (`a_i` = `b_i` = 1<<i, carry-in 0) appears at position i+1. At i = 31 it appears on `cout_o` instead.
- R7: With both operands and the carry-in at zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First addend |
| b_i | input | 32 | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry out of bit 31 |
| c_msb_o | output | 1 | Carry into bit 31, used for overflow detection |

## Verification
The bench builds the block with its default parameters: a 32-bit word split into four 8-bit groups. With this setting there are exactly three group-to-group carry links. Directed vectors can therefore force a carry across each link on its own and across all three at once. The single-bit generate sweep and the full-propagate chain exercise every flattened product term at both group edges. Pseudo-random vectors then compare against a 33-bit behavioural sum, and each one also checks the carry into the top bit.

// File: rtl/cla_grouped_adder.sv
module cla_grouped_adder #(
  parameter int WIDTH = 32,
  parameter int GRP   = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             c_msb_o
);

  localparam int NGRP = WIDTH / GRP;

  logic [WIDTH-1:0] gen, prp;
  logic [WIDTH:0]   cbit;

  assign gen = a_i & b_i;
  assign prp = a_i | b_i;

  always_comb begin
    logic grp_c;
    logic term;
    logic acc;
    cbit  = '0;
    grp_c = cin_i;
    for (int gi = 0; gi < NGRP; gi++) begin
      cbit[gi*GRP] = grp_c;
      for (int j = 0; j < GRP; j++) begin
        acc = 1'b0;
        for (int k = 0; k <= j + 1; k++) begin
          term = (k == 0) ? grp_c : gen[gi*GRP + k - 1];
          for (int m = k; m <= j; m++) term = term & prp[gi*GRP + m];
          acc = acc | term;
        end
        cbit[gi*GRP + j + 1] = acc;
      end
      grp_c = cbit[(gi+1)*GRP];
    end
  end

  assign sum_o   = a_i ^ b_i ^ cbit[WIDTH-1:0];
  assign cout_o  = cbit[WIDTH];
  assign c_msb_o = cbit[WIDTH-1];

  always_comb begin
    AST_SUM_MATCH: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})); // R1
    AST_MSB_CARRY: assert (c_msb_o == (a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ sum_o[WIDTH-1])); // R3
    AST_LOW_GROUP: assert (cbit[GRP] == (({1'b0, a_i[GRP-1:0]} + {1'b0, b_i[GRP-1:0]} + {{GRP{1'b0}}, cin_i}) >> GRP)); // R5
    AST_ALL_PROP: assert (!(&(a_i ^ b_i)) || (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})); // R4
    AST_ZERO_IN: assert (|{a_i, b_i, cin_i} || (sum_o == '0 && !cout_o && !c_msb_o)); // R7
  end

endmodule

// File: tb/sim_cla_grouped_adder.sv
`timescale 1ns/100ps
module sim_cla_grouped_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a, b, sum;
  logic cin, cout, cmsb;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cla_grouped_adder u0 (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .c_msb_o(cmsb)
  );

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #1;
  endtask

  task automatic check_all(input string req);
    logic [32:0] tot;
    logic [31:0] low;
    tot = {1'b0, a} + {1'b0, b} + {32'd0, cin};
    low = {1'b0, a[30:0]} + {1'b0, b[30:0]} + {31'd0, cin};
    checks++;
    if (sum !== tot[31:0]) begin
      fails++;
      $display("FAIL %s R1 a=%h b=%h cin=%b sum=%h expected %h", req, a, b, cin, sum, tot[31:0]);
    end
    checks++;
    if (cout !== tot[32]) begin
      fails++;
      $display("FAIL %s R2 a=%h b=%h cin=%b cout=%b expected %b", req, a, b, cin, cout, tot[32]);
    end
    checks++;
    if (cmsb !== low[31]) begin
      fails++;
      $display("FAIL %s R3 a=%h b=%h cin=%b c_msb=%b expected %b", req, a, b, cin, cmsb, low[31]);
    end
  endtask

  task automatic expect_val(input string req, input logic [31:0] es, input logic ec);
    checks++;
    if (sum !== es || cout !== ec) begin
      fails++;
      $display("FAIL %s sum=%h cout=%b expected %h %b", req, sum, cout, es, ec);
    end
  endtask

  task automatic t_zero;
    apply(32'd0, 32'd0, 1'b0);
    expect_val("R7", 32'd0, 1'b0);
    checks++;
    if (cmsb !== 1'b0) begin
      fails++;
      $display("FAIL R7 c_msb=%b expected 0", cmsb);
    end
  endtask

  task automatic t_full_chain;
    apply(32'hFFFF_FFFF, 32'd0, 1'b1);
    expect_val("R4", 32'd0, 1'b1);
    check_all("R4");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    expect_val("R4", 32'd0, 1'b1);
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    expect_val("R4", 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_boundaries;
    apply(32'h0000_00FF, 32'd0, 1'b1);
    expect_val("R5", 32'h0000_0100, 1'b0);
    apply(32'h0000_FF00, 32'h0000_0100, 1'b0);
    expect_val("R5", 32'h0001_0000, 1'b0);
    apply(32'h00FF_FFFF, 32'h0000_0001, 1'b0);
    expect_val("R5", 32'h0100_0000, 1'b0);
    apply(32'hFF00_0000, 32'h0100_0000, 1'b0);
    expect_val("R5", 32'h0000_0000, 1'b1);
  endtask

  task automatic t_generate;
    for (int i = 0; i < 32; i++) begin
      apply(32'd1 << i, 32'd1 << i, 1'b0);
      if (i == 31) expect_val("R6", 32'd0, 1'b1);
      else expect_val("R6", 32'd1 << (i + 1), 1'b0);
    end
  endtask

  task automatic t_overflow;
    apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    check_all("R3");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0);
    check_all("R3");
    apply(32'h4000_0000, 32'h4000_0000, 1'b0);
    check_all("R3");
  endtask

  task automatic t_random;
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int n = 0; n < 2000; n++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      a = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      apply(a, s, s[7]);
      check_all("R1");
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero();
    t_full_chain();
    t_boundaries();
    t_generate();
    t_overflow();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule